// File: doc/BRIEF.md
# Flash Program and Erase Engine

This engine owns a small byte-addressed storage array that behaves like NOR flash. A command sequencer hands it one request at a time: either a single-byte program or one of four erase sizes. The engine checks the write-enable latch and the per-device erase capability flags before it acts. A program can only clear bits unless the write-ones configuration is set, in which case the new byte replaces the old one. An erase writes 0xFF over its whole region at a rate of one byte per clock, and `busy` stays high while it runs. A registered read port lets the sequencer fetch stored bytes.

The engine remembers which page was programmed most recently. It reports that page on a flush strobe in two cases: when a program lands in a different page, and when the sequencer signals a new chip-select. A model of the backing store, or a testbench, can use that strobe to learn which page must be written back.

All sizes are parameters. The defaults are a scaled-down device: 16-byte pages, 64-byte and 256-byte small erases, and four 512-byte sectors (2048 bytes in total). A full-size part uses a 256-byte page, 4 KiB and 32 KiB small erases, and its own sector geometry.

The control is a three-state machine:

| State | Meaning |
|-------|---------|
| ST_IDLE | Waits for a request. |
| ST_PROG | Writes the merged byte for one cycle. |
| ST_ERASE | Writes one 0xFF byte per clock. |

Its transitions are:

| From | To | Condition |
|------|----|-----------|
| ST_IDLE | ST_PROG | An accepted program with the latch set. |
| ST_IDLE | ST_ERASE | An accepted, permitted erase with the latch set. |
| ST_PROG | ST_IDLE | Always, after one cycle. |
| ST_ERASE | ST_IDLE | After the last byte of the region is written. |
| ST_ERASE | ST_ERASE | Otherwise. |

Top module: `flash_pe_engine`

## Requirements
- R1: After reset, every storage byte reads 0xFF, and `busy`, `wel`, `cap_err`, `ones_warn` and `flush_valid` are all low.
- R2: The write-enable latch reads back on `wel` one cycle after `wel_set` or `wel_clr`. `wel_clr` wins when both are high in the same cycle.
- R3: With the latch set and `cfg_write_ones` low, opcode 0x02 stores the bitwise AND of the old byte and `op_data` at `op_addr`. `busy` is high for exactly one cycle.
- R4: With `cfg_write_ones` high, opcode 0x02 replaces the old byte with `op_data`.
- R5: `ones_warn` pulses for one cycle, in the cycle after the program's busy cycle, whenever `op_data` has a 1 where the old byte had a 0. This applies in both programming modes.
- R6: A program request made while the latch is clear changes nothing. It raises no `busy`, no `ones_warn` and no flush.
- R7: Erase opcodes 0x20, 0x52 and 0xD8 fill a region with 0xFF. The region is `SMALL_ERASE_BYTES`, `MID_ERASE_BYTES` or `SECTOR_BYTES` long, and starts at `op_addr` rounded down to that size. Opcode 0xC7 fills the whole device. Bytes outside the region keep their values.
- R8: Opcode 0x20 without `cfg_erase_small_ok`, or 0x52 without `cfg_erase_mid_ok`, erases nothing and raises no `busy`. Instead, `cap_err` pulses for one cycle right after the accepting edge. This check is made whatever the latch holds.
- R9: A permitted erase made while the latch is clear is dropped silently: no `busy`, no `cap_err`, and no storage change.
- R10: An erase holds `busy` high for exactly as many cycles as its region has bytes, starting the cycle after it is accepted. Requests that arrive while `busy` is high are ignored.
- R11: When a program lands in a page (address divided by `PAGE_BYTES`) different from the last programmed page, `flush_valid` pulses together with `ones_warn` timing, and `flush_page` carries the previous page. The first program, and programs within the same page, raise no flush.
- R12: `cs_assert` while idle flushes the dirty page, if there is one, on the next cycle and then clears it. `cs_assert` with no dirty page does nothing. A request in the same cycle as `cs_assert` is dropped.
- R13: `rd_data` returns the byte at `rd_addr` one clock after the address is presented.
- R14: Any other opcode is ignored: no `busy`, no flag, and no storage change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_erase_small_ok | input | 1 | Device supports the smallest erase (opcode 0x20) |
| cfg_erase_mid_ok | input | 1 | Device supports the middle erase (opcode 0x52) |
| cfg_write_ones | input | 1 | EEPROM-style mode: a program overwrites the old byte |
| wel_set | input | 1 | Set the write-enable latch |
| wel_clr | input | 1 | Clear the write-enable latch (has priority over set) |
| cs_assert | input | 1 | Chip-select start pulse; flushes the dirty page |
| op_valid | input | 1 | Request strobe |
| op_code | input | 8 | Request opcode |
| op_addr | input | ADDR_W | Request byte address |
| op_data | input | 8 | Program data |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | 8 | Read port data, one cycle latency |
| busy | output | 1 | A program or erase is in progress |
| wel | output | 1 | Write-enable latch state |
| cap_err | output | 1 | Pulse: the erase size is not supported |
| ones_warn | output | 1 | Pulse: a program tried to turn a 0 bit into a 1 |
| flush_valid | output | 1 | Pulse: `flush_page` holds a page to write back |
| flush_page | output | PG_W | Index of the flushed page |

## Verification
The programming path is swept over about two dozen addresses with varied data, so that plain AND-merging (where the old byte is all ones) can be told apart from a merge that warns (where bits were cleared earlier) and from overwrite mode. The same sweep crosses pages, so that dirty-page flushes are separated from programs that stay within one page. Every erase opcode is issued at an unaligned address over a pre-programmed array, and a full read-back of the array is compared with a bench-side byte model. This shows both where each region starts and where it ends. The erase opcodes are also issued with the capability flags or the latch withdrawn, so that the error path and the silent-drop path can be told apart.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    // Request opcodes decoded by the engine
    localparam logic [7:0] OP_PROGRAM      = 8'h02;
    localparam logic [7:0] OP_ERASE_SMALL  = 8'h20;
    localparam logic [7:0] OP_ERASE_MID    = 8'h52;
    localparam logic [7:0] OP_ERASE_SECTOR = 8'hD8;
    localparam logic [7:0] OP_ERASE_CHIP   = 8'hC7;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        K_NONE,
        K_PROG,
        K_ERASE
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE
    } eng_state_e;

endpackage

// File: rtl/flash_pe_decode.sv
module flash_pe_decode
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W            = 11,
    parameter int CNT_W             = 12,
    parameter int SMALL_ERASE_BYTES = 64,
    parameter int MID_ERASE_BYTES   = 256,
    parameter int SECTOR_BYTES      = 512,
    parameter int DEV_BYTES         = 2048
) (
    input  logic [7:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              small_ok,
    input  logic              mid_ok,
    output op_kind_e          kind,
    output logic              cap_fail,
    output logic [ADDR_W-1:0] er_base,
    output logic [CNT_W-1:0]  er_len
);

    localparam logic [ADDR_W-1:0] SMALL_MASK  = ADDR_W'(SMALL_ERASE_BYTES - 1);
    localparam logic [ADDR_W-1:0] MID_MASK    = ADDR_W'(MID_ERASE_BYTES - 1);
    localparam logic [ADDR_W-1:0] SECTOR_MASK = ADDR_W'(SECTOR_BYTES - 1);

    always_comb begin
        kind     = K_NONE;
        cap_fail = 1'b0;
        er_base  = '0;
        er_len   = '0;
        case (op_code)
            OP_PROGRAM: begin
                kind = K_PROG;
            end
            OP_ERASE_SMALL: begin
                kind     = K_ERASE;
                cap_fail = !small_ok;
                er_base  = op_addr & ~SMALL_MASK;
                er_len   = CNT_W'(SMALL_ERASE_BYTES);
            end
            OP_ERASE_MID: begin
                kind     = K_ERASE;
                cap_fail = !mid_ok;
                er_base  = op_addr & ~MID_MASK;
                er_len   = CNT_W'(MID_ERASE_BYTES);
            end
            OP_ERASE_SECTOR: begin
                kind    = K_ERASE;
                er_base = op_addr & ~SECTOR_MASK;
                er_len  = CNT_W'(SECTOR_BYTES);
            end
            OP_ERASE_CHIP: begin
                kind    = K_ERASE;
                er_base = '0;
                er_len  = CNT_W'(DEV_BYTES);
            end
            default: begin
                kind = K_NONE;
            end
        endcase
    end

endmodule

// File: rtl/flash_pe_store.sv
module flash_pe_store
    import flash_pe_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [7:0]        peek_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [DEPTH];

    // Combinational port used for the read-modify-write of a program
    assign peek_data = mem[peek_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= ERASED_BYTE;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= ERASED_BYTE;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/flash_pe_dirty.sv
module flash_pe_dirty #(
    parameter int PG_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_fire,
    input  logic [PG_W-1:0] prog_page,
    input  logic            cs_flush,
    output logic            flush_valid,
    output logic [PG_W-1:0] flush_page
);

    logic            dirty_vld;
    logic [PG_W-1:0] dirty_pg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_vld   <= 1'b0;
            dirty_pg    <= '0;
            flush_valid <= 1'b0;
            flush_page  <= '0;
        end else begin
            flush_valid <= 1'b0;
            if (prog_fire) begin
                if (dirty_vld && (dirty_pg != prog_page)) begin
                    flush_valid <= 1'b1;
                    flush_page  <= dirty_pg;
                end
                dirty_vld <= 1'b1;
                dirty_pg  <= prog_page;
            end else if (cs_flush) begin
                if (dirty_vld) begin
                    flush_valid <= 1'b1;
                    flush_page  <= dirty_pg;
                end
                dirty_vld <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
    import flash_pe_pkg::*;
#(
    parameter int PAGE_BYTES        = 16,
    parameter int SMALL_ERASE_BYTES = 64,
    parameter int MID_ERASE_BYTES   = 256,
    parameter int SECTOR_BYTES      = 512,
    parameter int SECTOR_COUNT      = 4,
    localparam int DEV_BYTES        = SECTOR_BYTES * SECTOR_COUNT,
    localparam int ADDR_W           = $clog2(DEV_BYTES),
    localparam int PG_W             = ADDR_W - $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_erase_small_ok,
    input  logic              cfg_erase_mid_ok,
    input  logic              cfg_write_ones,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              cs_assert,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              wel,
    output logic              cap_err,
    output logic              ones_warn,
    output logic              flush_valid,
    output logic [PG_W-1:0]   flush_page
);

    localparam int CNT_W   = ADDR_W + 1;
    localparam int PAGE_LG = $clog2(PAGE_BYTES);

    eng_state_e        state_q, state_d;
    op_kind_e          dec_kind;
    logic              dec_cap_fail;
    logic [ADDR_W-1:0] dec_base;
    logic [CNT_W-1:0]  dec_len;

    logic [ADDR_W-1:0] prog_addr_q;
    logic [7:0]        prog_data_q;
    logic [ADDR_W-1:0] er_ptr_q;
    logic [CNT_W-1:0]  er_left_q;

    logic              is_idle;
    logic              take_cs;
    logic              take_op;
    logic              start_prog;
    logic              start_erase;
    logic              cap_hit;
    logic              last_erase_byte;

    logic              st_wr_en;
    logic [ADDR_W-1:0] st_wr_addr;
    logic [7:0]        st_wr_data;
    logic [7:0]        old_byte;
    logic [7:0]        merged_byte;
    logic              raises_bits;

    flash_pe_decode #(
        .ADDR_W            (ADDR_W),
        .CNT_W             (CNT_W),
        .SMALL_ERASE_BYTES (SMALL_ERASE_BYTES),
        .MID_ERASE_BYTES   (MID_ERASE_BYTES),
        .SECTOR_BYTES      (SECTOR_BYTES),
        .DEV_BYTES         (DEV_BYTES)
    ) u_decode (
        .op_code  (op_code),
        .op_addr  (op_addr),
        .small_ok (cfg_erase_small_ok),
        .mid_ok   (cfg_erase_mid_ok),
        .kind     (dec_kind),
        .cap_fail (dec_cap_fail),
        .er_base  (dec_base),
        .er_len   (dec_len)
    );

    // Request acceptance: chip-select has priority, all requests wait for idle
    assign is_idle         = (state_q == ST_IDLE);
    assign take_cs         = is_idle && cs_assert;
    assign take_op         = is_idle && op_valid && !cs_assert;
    assign start_prog      = take_op && (dec_kind == K_PROG) && wel;
    assign cap_hit         = take_op && (dec_kind == K_ERASE) && dec_cap_fail;
    assign start_erase     = take_op && (dec_kind == K_ERASE) && !dec_cap_fail && wel;
    assign last_erase_byte = (er_left_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_prog) begin
                    state_d = ST_PROG;
                end else if (start_erase) begin
                    state_d = ST_ERASE;
                end
            end
            ST_PROG: begin
                state_d = ST_IDLE;
            end
            ST_ERASE: begin
                if (last_erase_byte) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Request capture and erase walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_addr_q <= '0;
            prog_data_q <= '0;
            er_ptr_q    <= '0;
            er_left_q   <= '0;
        end else begin
            if (start_prog) begin
                prog_addr_q <= op_addr;
                prog_data_q <= op_data;
            end
            if (start_erase) begin
                er_ptr_q  <= dec_base;
                er_left_q <= dec_len - CNT_W'(1);
            end else if (state_q == ST_ERASE) begin
                er_ptr_q  <= er_ptr_q + ADDR_W'(1);
                er_left_q <= er_left_q - CNT_W'(1);
            end
        end
    end

    // Write-enable latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (wel_clr) begin
            wel <= 1'b0;
        end else if (wel_set) begin
            wel <= 1'b1;
        end
    end

    // Storage write port selection
    assign merged_byte = cfg_write_ones ? prog_data_q : (old_byte & prog_data_q);
    assign raises_bits = |(~old_byte & prog_data_q);

    always_comb begin
        st_wr_en   = 1'b0;
        st_wr_addr = er_ptr_q;
        st_wr_data = ERASED_BYTE;
        unique case (state_q)
            ST_PROG: begin
                st_wr_en   = 1'b1;
                st_wr_addr = prog_addr_q;
                st_wr_data = merged_byte;
            end
            ST_ERASE: begin
                st_wr_en = 1'b1;
            end
            default: begin
                st_wr_en = 1'b0;
            end
        endcase
    end

    flash_pe_store #(
        .DEPTH  (DEV_BYTES),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (st_wr_en),
        .wr_addr   (st_wr_addr),
        .wr_data   (st_wr_data),
        .peek_addr (prog_addr_q),
        .peek_data (old_byte),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    flash_pe_dirty #(
        .PG_W (PG_W)
    ) u_dirty (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_fire   (state_q == ST_PROG),
        .prog_page   (prog_addr_q[ADDR_W-1:PAGE_LG]),
        .cs_flush    (take_cs),
        .flush_valid (flush_valid),
        .flush_page  (flush_page)
    );

    // Output process
    assign busy = !is_idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_err   <= 1'b0;
            ones_warn <= 1'b0;
        end else begin
            cap_err   <= cap_hit;
            ones_warn <= (state_q == ST_PROG) && raises_bits;
        end
    end

endmodule

// File: rtl/flash_pe_checker.sv
module flash_pe_checker (
    input logic clk,
    input logic rst_n,
    input logic op_valid,
    input logic cs_assert,
    input logic wel_set,
    input logic wel_clr,
    input logic busy,
    input logic wel,
    input logic cap_err,
    input logic ones_warn,
    input logic flush_valid
);

    // R2
    wel_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wel);

    // R2
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_set && !wel_clr) |=> wel);

    // R6
    no_start_without_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && !wel) |=> !busy);

    // R8
    cap_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_err |-> (!busy && $past(op_valid)));

    // R5
    warn_after_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ones_warn |-> $past(busy));

    // R11
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> ($past(busy) || $past(cs_assert)));

endmodule

bind flash_pe_engine flash_pe_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .cs_assert   (cs_assert),
    .wel_set     (wel_set),
    .wel_clr     (wel_clr),
    .busy        (busy),
    .wel         (wel),
    .cap_err     (cap_err),
    .ones_warn   (ones_warn),
    .flush_valid (flush_valid)
);

// File: tb/flash_pe_engine_bench.sv
module flash_pe_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PAGE       = 16;
    localparam int SMALL      = 64;
    localparam int MID        = 256;
    localparam int SECT       = 512;
    localparam int NSECT      = 4;
    localparam int DEV        = SECT * NSECT;
    localparam int AW         = $clog2(DEV);
    localparam int PW         = AW - $clog2(PAGE);
    localparam int WATCHDOG   = 180000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_erase_small_ok = 1'b1;
    logic          cfg_erase_mid_ok = 1'b1;
    logic          cfg_write_ones = 1'b0;
    logic          wel_set = 1'b0;
    logic          wel_clr = 1'b0;
    logic          cs_assert = 1'b0;
    logic          op_valid = 1'b0;
    logic [7:0]    op_code = 8'h00;
    logic [AW-1:0] op_addr = '0;
    logic [7:0]    op_data = 8'h00;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;
    logic          wel;
    logic          cap_err;
    logic          ones_warn;
    logic          flush_valid;
    logic [PW-1:0] flush_page;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_mem [DEV];
    bit m_wel = 1'b0;
    bit d_vld = 1'b0;
    int d_pg  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_pe_engine #(
        .PAGE_BYTES        (PAGE),
        .SMALL_ERASE_BYTES (SMALL),
        .MID_ERASE_BYTES   (MID),
        .SECTOR_BYTES      (SECT),
        .SECTOR_COUNT      (NSECT)
    ) u_flash_pe_engine (
        .clk                (clk),
        .rst_n              (rst_n),
        .cfg_erase_small_ok (cfg_erase_small_ok),
        .cfg_erase_mid_ok   (cfg_erase_mid_ok),
        .cfg_write_ones     (cfg_write_ones),
        .wel_set            (wel_set),
        .wel_clr            (wel_clr),
        .cs_assert          (cs_assert),
        .op_valid           (op_valid),
        .op_code            (op_code),
        .op_addr            (op_addr),
        .op_data            (op_data),
        .rd_addr            (rd_addr),
        .rd_data            (rd_data),
        .busy               (busy),
        .wel                (wel),
        .cap_err            (cap_err),
        .ones_warn          (ones_warn),
        .flush_valid        (flush_valid),
        .flush_page         (flush_page)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R13 read latency is relied on here: data follows the address by one edge
    task automatic check_mem(input string tag);
        int bad = 0;
        int b_addr = 0;
        int b_act = 0;
        int b_exp = 0;
        for (int a = 0; a < DEV; a++) begin
            rd_addr = AW'(a);
            tick();
            if (rd_data !== exp_mem[a]) begin
                if (bad == 0) begin
                    b_addr = a;
                    b_act = int'(rd_data);
                    b_exp = int'(exp_mem[a]);
                end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: %0d bytes differ, first at %0h actual %0h expected %0h",
                     tag, bad, b_addr, b_act, b_exp);
        end
    endtask

    task automatic set_wel(input bit s, input bit c);
        wel_set = s;
        wel_clr = c;
        tick();
        wel_set = 1'b0;
        wel_clr = 1'b0;
        if (c) m_wel = 1'b0;
        else if (s) m_wel = 1'b1;
    endtask

    task automatic do_op(input logic [7:0] code, input int addr, input logic [7:0] data,
                         input string tag);
        int  exp_busy = 0;
        bit  exp_cap = 1'b0;
        bit  exp_warn = 1'b0;
        bit  exp_fl = 1'b0;
        int  exp_pg = 0;
        int  len = 0;
        int  base;
        int  n = 0;
        bit  g_cap, g_warn, g_fl;
        int  g_pg;
        logic [7:0] old;
        // bench-side model
        if (code == 8'h02) begin
            if (m_wel) begin
                old = exp_mem[addr];
                exp_busy = 1;
                exp_warn = ((~old) & data) != 8'h00;
                exp_mem[addr] = cfg_write_ones ? data : (old & data);
                if (d_vld && d_pg != addr / PAGE) begin
                    exp_fl = 1'b1;
                    exp_pg = d_pg;
                end
                d_vld = 1'b1;
                d_pg = addr / PAGE;
            end
        end else if (code == 8'h20 || code == 8'h52 || code == 8'hD8 || code == 8'hC7) begin
            len = (code == 8'h20) ? SMALL : (code == 8'h52) ? MID : (code == 8'hD8) ? SECT : DEV;
            if ((code == 8'h20 && !cfg_erase_small_ok) || (code == 8'h52 && !cfg_erase_mid_ok)) begin
                exp_cap = 1'b1;
            end else if (m_wel) begin
                base = (code == 8'hC7) ? 0 : addr - (addr % len);
                for (int i = 0; i < len; i++) exp_mem[base + i] = 8'hFF;
                exp_busy = len;
            end
        end
        // drive one request
        op_code = code;
        op_addr = AW'(addr);
        op_data = data;
        op_valid = 1'b1;
        tick();
        op_valid = 1'b0;
        g_cap = cap_err;
        g_warn = ones_warn;
        g_fl = flush_valid;
        g_pg = int'(flush_page);
        while (busy) begin
            tick();
            n++;
            g_warn = ones_warn;
            g_fl = flush_valid;
            g_pg = int'(flush_page);
        end
        chk({tag, " busy cycles"}, n, exp_busy);
        chk({tag, " R8 cap_err"}, int'(g_cap), int'(exp_cap));
        chk({tag, " R5 ones_warn"}, int'(g_warn), int'(exp_warn));
        chk({tag, " R11 flush_valid"}, int'(g_fl), int'(exp_fl));
        if (exp_fl) chk({tag, " R11 flush_page"}, g_pg, exp_pg);
    endtask

    task automatic cs_pulse(input string tag);
        bit exp_fl = d_vld;
        int exp_pg = d_pg;
        d_vld = 1'b0;
        cs_assert = 1'b1;
        tick();
        cs_assert = 1'b0;
        chk({tag, " flush_valid"}, int'(flush_valid), int'(exp_fl));
        if (exp_fl) chk({tag, " flush_page"}, int'(flush_page), exp_pg);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEV; a++) exp_mem[a] = 8'hFF;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 wel", int'(wel), 0);
        chk("R1 cap_err", int'(cap_err), 0);
        chk("R1 ones_warn", int'(ones_warn), 0);
        chk("R1 flush_valid", int'(flush_valid), 0);
        check_mem("R1 erased array");

        // R2 latch
        set_wel(1'b1, 1'b0);
        chk("R2 set", int'(wel), 1);
        set_wel(1'b1, 1'b1);
        chk("R2 clear priority", int'(wel), 0);
        set_wel(1'b1, 1'b0);

        // R3 / R11 sweep across pages
        for (int i = 0; i < 24; i++) begin
            do_op(8'h02, (i * 89 + 7) % DEV, 8'((i * 53) ^ 8'h5A), "R3 sweep");
        end
        do_op(8'h02, 'h005, 8'h0F, "R3 and");
        do_op(8'h02, 'h005, 8'hF0, "R5 and-warn");
        do_op(8'h02, 'h006, 8'h3C, "R11 same page");

        // R4 overwrite mode
        cfg_write_ones = 1'b1;
        do_op(8'h02, 'h005, 8'hA5, "R4 overwrite");
        do_op(8'h02, 'h005, 8'h00, "R4 overwrite zero");
        cfg_write_ones = 1'b0;

        // R6 program without latch
        set_wel(1'b0, 1'b1);
        do_op(8'h02, 'h010, 8'h00, "R6 no latch");
        set_wel(1'b1, 1'b0);
        check_mem("R3 R4 R6 contents");

        // R7 / R10 erases at unaligned addresses
        do_op(8'h20, 'h047, 8'h00, "R7 small erase");
        check_mem("R7 small region");
        do_op(8'h52, 'h3A5, 8'h00, "R7 mid erase");
        do_op(8'hD8, 'h6F0, 8'h00, "R7 sector erase");
        check_mem("R7 mid and sector regions");

        // R8 capability gating
        do_op(8'h02, 'h0C3, 8'h00, "R3 prep");
        cfg_erase_small_ok = 1'b0;
        do_op(8'h20, 'h0C3, 8'h00, "R8 small denied");
        set_wel(1'b0, 1'b1);
        do_op(8'h20, 'h0C8, 8'h00, "R8 denied without latch");
        set_wel(1'b1, 1'b0);
        cfg_erase_mid_ok = 1'b0;
        do_op(8'h52, 'h0C3, 8'h00, "R8 mid denied");
        cfg_erase_small_ok = 1'b1;
        cfg_erase_mid_ok = 1'b1;
        check_mem("R8 contents kept");

        // R9 erase with latch clear
        set_wel(1'b0, 1'b1);
        do_op(8'hD8, 'h0C3, 8'h00, "R9 sector dropped");
        do_op(8'hC7, 'h000, 8'h00, "R9 chip dropped");
        set_wel(1'b1, 1'b0);

        // R14 unknown opcodes
        do_op(8'h03, 'h0C3, 8'h00, "R14 opcode 03");
        do_op(8'h9F, 'h0C3, 8'h00, "R14 opcode 9F");
        do_op(8'h00, 'h0C3, 8'h00, "R14 opcode 00");
        check_mem("R9 R14 contents kept");

        // R10 requests during busy are ignored
        begin
            int n = 0;
            do_op(8'h02, 'h500, 8'h11, "R10 prep");
            for (int i = 0; i < SMALL; i++) exp_mem['h100 + i] = 8'hFF;
            op_code = 8'h20;
            op_addr = AW'('h11F);
            op_valid = 1'b1;
            tick();
            op_code = 8'h02;
            op_addr = AW'('h500);
            op_data = 8'h00;
            tick();
            n++;
            op_valid = 1'b0;
            while (busy) begin
                tick();
                n++;
            end
            chk("R10 erase busy length", n, SMALL);
            rd_addr = AW'('h500);
            tick();
            chk("R10 ignored program", int'(rd_data), int'(exp_mem['h500]));
        end

        // R12 chip-select flush
        cs_pulse("R12 flush dirty");
        cs_pulse("R12 nothing dirty");
        do_op(8'h02, 'h234, 8'h77, "R11 new page");
        op_code = 8'h02;
        op_addr = AW'('h235);
        op_data = 8'h00;
        op_valid = 1'b1;
        cs_pulse("R12 cs with request");
        op_valid = 1'b0;
        chk("R12 request dropped busy", int'(busy), 0);
        rd_addr = AW'('h235);
        tick();
        chk("R12 request dropped data", int'(rd_data), int'(exp_mem['h235]));

        // R13 explicit read latency
        rd_addr = AW'('h234);
        #1;
        chk("R13 before edge", int'(rd_data), int'(exp_mem['h235]));
        tick();
        chk("R13 after edge", int'(rd_data), int'(exp_mem['h234]));

        // R7 chip erase
        do_op(8'hC7, 'h123, 8'h00, "R7 chip erase");
        check_mem("R7 whole device");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule